// File: doc/BRIEF.md
# Shared Two-Port Memory with Contention Flags and Mailbox Doorbells

This block is a 1024-word by 8-bit memory that two agents, called left and right, reach through two ports that are fully independent of each other. Each port has an active-low select, a write strobe, an active-low output enable, a 10-bit address and separate 8-bit write and read data buses. All ports are sampled on one clock. Read data comes back one clock after the request.

When both ports select the same word, the block settles the contention. The port that has held that address longer wins. If both arrive in the same cycle, the left port wins. The losing port sees its conflict flag go low, and any write it attempts is dropped. Reads are never blocked.

The two highest words serve as mailboxes. The top word belongs to the left port, and the word below it belongs to the right port. When the opposite port writes a mailbox word, the owner's doorbell goes low. When the owner reads its own mailbox word, the doorbell is released.

A parameter selects expansion (slave) mode. In that mode the block does no arbitration of its own and drives its conflict flags high. Each port then relies only on its external hold input, which lets a second bank follow the first bank's contention decisions.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written through either port is returned by a later read of that address through either port; the read data and the read-valid flag appear at the first clock edge after the read is sampled. Encoding: wr_n low means write, high means read.
- R2: A port whose sel_n is high makes no access: a write strobe is ignored, the memory is unchanged, and the next cycle shows read-valid low and read data zero. A read with out_en_n high gives the same: read-valid low and data zero.
- R3: Both ports may read the same word in the same cycle, and both receive the stored value.
- R4: When both ports select the same address, the port that already held that address in the previous cycle wins. The other port's conflict_n is low in the following cycle. The two conflict_n flags are never low together, and both return high once the addresses differ.
- R5: When both ports reach the same address in the same cycle, the right port loses. That result persists for as long as both keep that address.
- R6: A write from a losing port is dropped, and the memory keeps its old value. A read that loses while the winner writes returns the contents from before that write.
- R7: A write by the right port to address 0x3FF drives left doorbell_n low from the next cycle. A read of 0x3FF by the left port releases it.
- R8: A write by the left port to address 0x3FE drives right doorbell_n low from the next cycle. A read of 0x3FE by the right port releases it.
- R9: A dropped write to a mailbox word does not ring the doorbell. If a ring and a release of the same doorbell occur in one cycle, the doorbell ends low.
- R10: In slave mode both conflict_n outputs stay high, even when both ports hit the same address. In either mode, a low hold_n on a port drops that port's write in that cycle.
- R11: During and after reset, with no access, conflict_n and doorbell_n are high and read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left port select, active low |
| l_wr_n | input | 1 | Left write strobe: 0 write, 1 read |
| l_out_en_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_hold_n | input | 1 | Left external write block, active low |
| l_conflict_n | output | 1 | Left lost a contention, active low |
| l_doorbell_n | output | 1 | Left mailbox doorbell, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_wr_n | input | 1 | Right write strobe: 0 write, 1 read |
| r_out_en_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_hold_n | input | 1 | Right external write block, active low |
| r_conflict_n | output | 1 | Right lost a contention, active low |
| r_doorbell_n | output | 1 | Right mailbox doorbell, active low |

## Verification
The doorbell properties assume that a write to a mailbox word is dropped only when the other port is also on that word or when the writer's hold_n is low. For that reason they are stated only for cycles in which the opposite port is elsewhere and hold_n is high. In the master instance, the stimulus keeps both hold_n inputs high. The slave instance drives hold_n low only in cycles where the bench expects a dropped write. All inputs change half a clock away from the sampling edge, so every port sees stable values when it is sampled. Contention is created on purpose with staggered arrivals from each side and with simultaneous arrivals, so that every winner rule is exercised.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_act,
   input  logic [AW-1:0] l_addr,
   input  logic          r_act,
   input  logic [AW-1:0] r_addr,
   output logic          l_lose,
   output logic          r_lose
);
   import dpm_pkg::*;

   logic          l_prev, r_prev;
   logic [AW-1:0] l_prev_addr, r_prev_addr;
   owner_e        owner_q;
   logic          match, l_keep, r_keep, right_first;

   always_comb begin
      match  = l_act & r_act & (l_addr == r_addr);
      l_keep = l_prev & (l_prev_addr == l_addr);
      r_keep = r_prev & (r_prev_addr == r_addr);
      if (l_keep & r_keep)
         right_first = (owner_q == OWN_RIGHT);
      else
         right_first = r_keep & ~l_keep;
      l_lose = match & right_first;
      r_lose = match & ~right_first;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_prev      <= 1'b0;
         r_prev      <= 1'b0;
         l_prev_addr <= '0;
         r_prev_addr <= '0;
         owner_q     <= OWN_NONE;
      end else begin
         l_prev      <= l_act;
         r_prev      <= r_act;
         l_prev_addr <= l_addr;
         r_prev_addr <= r_addr;
         if (match)
            owner_q <= right_first ? OWN_RIGHT : OWN_LEFT;
         else
            owner_q <= OWN_NONE;
      end
   end
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          l_we,
   input  logic          l_re,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_wdata,
   output logic [DW-1:0] l_q,
   input  logic          r_we,
   input  logic          r_re,
   input  logic [AW-1:0] r_addr,
   input  logic [DW-1:0] r_wdata,
   output logic [DW-1:0] r_q
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (l_re) l_q <= mem[l_addr];
      if (r_re) r_q <= mem[r_addr];
      if (r_we) mem[r_addr] <= r_wdata;
      if (l_we) mem[l_addr] <= l_wdata;
   end
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_wr,
   input  logic          l_rd,
   input  logic [AW-1:0] l_addr,
   input  logic          r_wr,
   input  logic          r_rd,
   input  logic [AW-1:0] r_addr,
   output logic          l_doorbell_n,
   output logic          r_doorbell_n
);
   localparam logic [AW-1:0] LBOX = {AW{1'b1}};
   localparam logic [AW-1:0] RBOX = LBOX - 1'b1;

   logic l_ring, l_ack, r_ring, r_ack;

   assign l_ring = r_wr & (r_addr == LBOX);
   assign l_ack  = l_rd & (l_addr == LBOX);
   assign r_ring = l_wr & (l_addr == RBOX);
   assign r_ack  = r_rd & (r_addr == RBOX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_doorbell_n <= 1'b1;
         r_doorbell_n <= 1'b1;
      end else begin
         if (l_ring)     l_doorbell_n <= 1'b0;
         else if (l_ack) l_doorbell_n <= 1'b1;
         if (r_ring)     r_doorbell_n <= 1'b0;
         else if (r_ack) r_doorbell_n <= 1'b1;
      end
   end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
   parameter int AW       = 10,
   parameter int DW       = 8,
   parameter bit IS_SLAVE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_sel_n,
   input  logic          l_wr_n,
   input  logic          l_out_en_n,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_wdata,
   output logic [DW-1:0] l_rdata,
   output logic          l_rvalid,
   input  logic          l_hold_n,
   output logic          l_conflict_n,
   output logic          l_doorbell_n,
   input  logic          r_sel_n,
   input  logic          r_wr_n,
   input  logic          r_out_en_n,
   input  logic [AW-1:0] r_addr,
   input  logic [DW-1:0] r_wdata,
   output logic [DW-1:0] r_rdata,
   output logic          r_rvalid,
   input  logic          r_hold_n,
   output logic          r_conflict_n,
   output logic          r_doorbell_n
);
   if (AW < 2) begin : g_bad_aw
      $error("dpram_mailbox: AW must be at least 2 for two mailbox words");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dpram_mailbox: DW must be positive");
   end

   logic          l_act, r_act, l_rd, r_rd, l_we, r_we;
   logic          l_lose, r_lose;
   logic          l_vq, r_vq;
   logic [DW-1:0] l_q, r_q;

   assign l_act = ~l_sel_n;
   assign r_act = ~r_sel_n;
   assign l_rd  = l_act & l_wr_n;
   assign r_rd  = r_act & r_wr_n;
   assign l_we  = l_act & ~l_wr_n & ~l_lose & l_hold_n;
   assign r_we  = r_act & ~r_wr_n & ~r_lose & r_hold_n;

   if (IS_SLAVE) begin : g_slave
      assign l_lose       = 1'b0;
      assign r_lose       = 1'b0;
      assign l_conflict_n = 1'b1;
      assign r_conflict_n = 1'b1;
   end else begin : g_master
      logic l_cf_q, r_cf_q;
      dpm_arbiter #(.AW(AW)) i_arb (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_act  (l_act),
         .l_addr (l_addr),
         .r_act  (r_act),
         .r_addr (r_addr),
         .l_lose (l_lose),
         .r_lose (r_lose)
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            l_cf_q <= 1'b1;
            r_cf_q <= 1'b1;
         end else begin
            l_cf_q <= ~l_lose;
            r_cf_q <= ~r_lose;
         end
      end
      assign l_conflict_n = l_cf_q;
      assign r_conflict_n = r_cf_q;
   end

   dpm_store #(.AW(AW), .DW(DW)) i_store (
      .clk     (clk),
      .l_we    (l_we),
      .l_re    (l_rd),
      .l_addr  (l_addr),
      .l_wdata (l_wdata),
      .l_q     (l_q),
      .r_we    (r_we),
      .r_re    (r_rd),
      .r_addr  (r_addr),
      .r_wdata (r_wdata),
      .r_q     (r_q)
   );

   dpm_mailbox #(.AW(AW)) i_mbox (
      .clk          (clk),
      .rst_n        (rst_n),
      .l_wr         (l_we),
      .l_rd         (l_rd),
      .l_addr       (l_addr),
      .r_wr         (r_we),
      .r_rd         (r_rd),
      .r_addr       (r_addr),
      .l_doorbell_n (l_doorbell_n),
      .r_doorbell_n (r_doorbell_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_vq <= 1'b0;
         r_vq <= 1'b0;
      end else begin
         l_vq <= l_rd & ~l_out_en_n;
         r_vq <= r_rd & ~r_out_en_n;
      end
   end

   assign l_rvalid = l_vq;
   assign r_rvalid = r_vq;
   assign l_rdata  = l_vq ? l_q : '0;
   assign r_rdata  = r_vq ? r_q : '0;
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          l_sel_n,
   input logic          l_wr_n,
   input logic          l_out_en_n,
   input logic [AW-1:0] l_addr,
   input logic [DW-1:0] l_wdata,
   input logic [DW-1:0] l_rdata,
   input logic          l_rvalid,
   input logic          l_hold_n,
   input logic          l_conflict_n,
   input logic          l_doorbell_n,
   input logic          r_sel_n,
   input logic          r_wr_n,
   input logic          r_out_en_n,
   input logic [AW-1:0] r_addr,
   input logic [DW-1:0] r_wdata,
   input logic [DW-1:0] r_rdata,
   input logic          r_rvalid,
   input logic          r_hold_n,
   input logic          r_conflict_n,
   input logic          r_doorbell_n
);
   localparam logic [AW-1:0] LBOX = {AW{1'b1}};
   localparam logic [AW-1:0] RBOX = LBOX - 1'b1;

   // R4
   no_dual_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_conflict_n && !r_conflict_n));

   // R4
   conflict_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel_n || r_sel_n || (l_addr != r_addr)) |=> (l_conflict_n && r_conflict_n));

   // R1
   l_valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel_n && l_wr_n && !l_out_en_n) |=> l_rvalid);

   // R2
   l_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel_n || l_out_en_n) |=> (!l_rvalid && (l_rdata == '0)));

   // R2
   r_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sel_n || r_out_en_n) |=> (!r_rvalid && (r_rdata == '0)));

   // R7
   l_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_sel_n && !r_wr_n && r_hold_n && (r_addr == LBOX) && (l_sel_n || l_addr != LBOX))
      |=> !l_doorbell_n);

   // R7
   l_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel_n && l_wr_n && (l_addr == LBOX) && (r_sel_n || r_wr_n || r_addr != LBOX))
      |=> l_doorbell_n);

   // R8
   r_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel_n && !l_wr_n && l_hold_n && (l_addr == RBOX) && (r_sel_n || r_addr != RBOX))
      |=> !r_doorbell_n);

   // R8
   r_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_sel_n && r_wr_n && (r_addr == RBOX) && (l_sel_n || l_wr_n || l_addr != RBOX))
      |=> r_doorbell_n);
endmodule

bind dpram_mailbox dpm_checker #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_dpram_mailbox.sv
module test_dpram_mailbox;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // master instance signals
   logic       ml_sel_n = 1, ml_wr_n = 1, ml_oe_n = 0, ml_hold_n = 1;
   logic [9:0] ml_addr = '0;
   logic [7:0] ml_wdata = '0, ml_rdata;
   logic       ml_valid, ml_cf_n, ml_db_n;
   logic       mr_sel_n = 1, mr_wr_n = 1, mr_oe_n = 0, mr_hold_n = 1;
   logic [9:0] mr_addr = '0;
   logic [7:0] mr_wdata = '0, mr_rdata;
   logic       mr_valid, mr_cf_n, mr_db_n;
   // slave instance signals
   logic       sl_sel_n = 1, sl_wr_n = 1, sl_hold_n = 1;
   logic [9:0] sl_addr = '0;
   logic [7:0] sl_wdata = '0, sl_rdata;
   logic       sl_valid, sl_cf_n, sl_db_n;
   logic       sr_sel_n = 1, sr_wr_n = 1, sr_hold_n = 1;
   logic [9:0] sr_addr = '0;
   logic [7:0] sr_wdata = '0, sr_rdata;
   logic       sr_valid, sr_cf_n, sr_db_n;

   dpram_mailbox i_dpram_mailbox (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(ml_sel_n), .l_wr_n(ml_wr_n), .l_out_en_n(ml_oe_n), .l_addr(ml_addr),
      .l_wdata(ml_wdata), .l_rdata(ml_rdata), .l_rvalid(ml_valid), .l_hold_n(ml_hold_n),
      .l_conflict_n(ml_cf_n), .l_doorbell_n(ml_db_n),
      .r_sel_n(mr_sel_n), .r_wr_n(mr_wr_n), .r_out_en_n(mr_oe_n), .r_addr(mr_addr),
      .r_wdata(mr_wdata), .r_rdata(mr_rdata), .r_rvalid(mr_valid), .r_hold_n(mr_hold_n),
      .r_conflict_n(mr_cf_n), .r_doorbell_n(mr_db_n)
   );

   dpram_mailbox #(.IS_SLAVE(1'b1)) i_dpram_mailbox_slv (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(sl_sel_n), .l_wr_n(sl_wr_n), .l_out_en_n(1'b0), .l_addr(sl_addr),
      .l_wdata(sl_wdata), .l_rdata(sl_rdata), .l_rvalid(sl_valid), .l_hold_n(sl_hold_n),
      .l_conflict_n(sl_cf_n), .l_doorbell_n(sl_db_n),
      .r_sel_n(sr_sel_n), .r_wr_n(sr_wr_n), .r_out_en_n(1'b0), .r_addr(sr_addr),
      .r_wdata(sr_wdata), .r_rdata(sr_rdata), .r_rvalid(sr_valid), .r_hold_n(sr_hold_n),
      .r_conflict_n(sr_cf_n), .r_doorbell_n(sr_db_n)
   );

   logic [7:0] ql[$];
   logic [7:0] qr[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic lop(input bit en, input bit wr, input logic [9:0] a, input logic [7:0] d);
      ml_sel_n = !en; ml_wr_n = !wr; ml_oe_n = 1'b0; ml_addr = a; ml_wdata = d;
   endtask

   task automatic rop(input bit en, input bit wr, input logic [9:0] a, input logic [7:0] d);
      mr_sel_n = !en; mr_wr_n = !wr; mr_oe_n = 1'b0; mr_addr = a; mr_wdata = d;
   endtask

   // scoreboard monitor: read results pop the expected queues (R1)
   always @(negedge clk) begin
      if (rst_n) begin
         if (ml_valid) begin
            if (ql.size() == 0) chk(1'b0, "R1 left unexpected valid", ml_rdata, 0);
            else begin
               logic [7:0] e;
               e = ql.pop_front();
               chk(ml_rdata == e, "R1 left read data", ml_rdata, e);
            end
         end
         if (mr_valid) begin
            if (qr.size() == 0) chk(1'b0, "R1 right unexpected valid", mr_rdata, 0);
            else begin
               logic [7:0] e;
               e = qr.pop_front();
               chk(mr_rdata == e, "R1 right read data", mr_rdata, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) tick();
      // R11 reset state
      chk(ml_cf_n && mr_cf_n, "R11 conflict reset", {ml_cf_n, mr_cf_n}, 3);
      chk(ml_db_n && mr_db_n, "R11 doorbell reset", {ml_db_n, mr_db_n}, 3);
      chk(!ml_valid && !mr_valid, "R11 valid reset", {ml_valid, mr_valid}, 0);
      rst_n = 1'b1;
      tick();
      chk(ml_cf_n && mr_cf_n && ml_db_n && mr_db_n, "R11 idle after reset",
          {ml_cf_n, mr_cf_n, ml_db_n, mr_db_n}, 15);

      // R1 basic write/read both ports
      lop(1, 1, 10'd5, 8'hA5); tick();
      lop(1, 0, 10'd5, 0); ql.push_back(8'hA5); rop(1, 1, 10'd9, 8'h3C); tick();
      lop(0, 0, 0, 0); rop(1, 0, 10'd9, 0); qr.push_back(8'h3C); tick();
      rop(0, 0, 0, 0); tick();

      // R2 deselected write ignored, output enable high gives no data
      ml_sel_n = 1; ml_wr_n = 0; ml_addr = 10'd5; ml_wdata = 8'hFF; tick();
      lop(1, 0, 10'd5, 0); ml_oe_n = 1'b1; tick();
      chk(!ml_valid && ml_rdata == 0, "R2 out_en high quiet", ml_rdata, 0);
      lop(1, 0, 10'd5, 0); ql.push_back(8'hA5); tick();
      lop(0, 0, 0, 0); tick();
      chk(!ml_valid, "R2 deselect no valid", ml_valid, 0);

      // R3 / R5 simultaneous read of one word
      lop(1, 0, 10'd5, 0); rop(1, 0, 10'd5, 0); ql.push_back(8'hA5); qr.push_back(8'hA5); tick();
      chk(!mr_cf_n && ml_cf_n, "R5 tie right loses", {ml_cf_n, mr_cf_n}, 2);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();
      chk(ml_cf_n && mr_cf_n, "R4 release", {ml_cf_n, mr_cf_n}, 3);

      // R4 / R6 left arrives first, right write dropped
      lop(1, 1, 10'd20, 8'h11); tick();
      chk(ml_cf_n && mr_cf_n, "R4 alone no conflict", {ml_cf_n, mr_cf_n}, 3);
      rop(1, 1, 10'd20, 8'h99); tick();
      chk(!mr_cf_n && ml_cf_n, "R4 left holder wins", {ml_cf_n, mr_cf_n}, 2);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();
      lop(1, 0, 10'd20, 0); ql.push_back(8'h11); tick();   // R6
      lop(0, 0, 0, 0); tick();

      // R4 / R6 right arrives first, left write dropped
      rop(1, 1, 10'd30, 8'h77); tick();
      lop(1, 1, 10'd30, 8'h55); tick();
      chk(!ml_cf_n && mr_cf_n, "R4 right holder wins", {ml_cf_n, mr_cf_n}, 1);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();
      rop(1, 0, 10'd30, 0); qr.push_back(8'h77); tick();   // R6
      rop(0, 0, 0, 0); tick();

      // R5 / R6 persisting tie, losing reader sees old then new contents
      lop(1, 1, 10'd40, 8'h10); tick();
      lop(0, 0, 0, 0); tick();
      lop(1, 1, 10'd40, 8'h42); rop(1, 0, 10'd40, 0); qr.push_back(8'h10); tick();
      chk(!mr_cf_n, "R6 right loses tie", mr_cf_n, 0);
      qr.push_back(8'h42); tick();
      chk(!mr_cf_n && ml_cf_n, "R5 result persists", {ml_cf_n, mr_cf_n}, 2);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();

      // R7 left mailbox
      rop(1, 1, 10'h3FF, 8'hAB); tick();
      chk(!ml_db_n && mr_db_n, "R7 ring left", {ml_db_n, mr_db_n}, 1);
      rop(0, 0, 0, 0); lop(1, 0, 10'h3FF, 0); ql.push_back(8'hAB); tick();
      chk(ml_db_n, "R7 release left", ml_db_n, 1);
      lop(0, 0, 0, 0); tick();

      // R8 right mailbox
      lop(1, 1, 10'h3FE, 8'hCD); tick();
      chk(!mr_db_n && ml_db_n, "R8 ring right", {ml_db_n, mr_db_n}, 2);
      lop(0, 0, 0, 0); rop(1, 0, 10'h3FE, 0); qr.push_back(8'hCD); tick();
      chk(mr_db_n, "R8 release right", mr_db_n, 1);
      rop(0, 0, 0, 0); tick();

      // R9 dropped mailbox write does not ring
      lop(1, 0, 10'h3FF, 0); rop(1, 1, 10'h3FF, 8'hEE); ql.push_back(8'hAB); tick();
      chk(ml_db_n, "R9 dropped write no ring", ml_db_n, 1);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();
      lop(1, 0, 10'h3FF, 0); ql.push_back(8'hAB); tick();   // R6
      lop(0, 0, 0, 0); tick();
      // R9 ring and release in one cycle
      rop(1, 1, 10'h3FF, 8'hEE); tick();
      chk(!ml_db_n, "R9 ring before coincide", ml_db_n, 0);
      lop(1, 0, 10'h3FF, 0); ql.push_back(8'hEE); tick();
      chk(!ml_db_n && !ml_cf_n, "R9 ring wins over release", {ml_db_n, ml_cf_n}, 0);
      lop(0, 0, 0, 0); rop(0, 0, 0, 0); tick();
      lop(1, 0, 10'h3FF, 0); ql.push_back(8'hEE); tick();
      chk(ml_db_n, "R9 later release", ml_db_n, 1);
      lop(0, 0, 0, 0); tick(); tick();
      chk(ql.size() == 0 && qr.size() == 0, "R1 all reads returned", ql.size() + qr.size(), 0);

      // R10 slave mode
      sl_sel_n = 0; sl_wr_n = 0; sl_addr = 10'd7; sl_wdata = 8'h01; tick();
      sl_wdata = 8'h12; sl_hold_n = 0;
      sr_sel_n = 0; sr_wr_n = 0; sr_addr = 10'd8; sr_wdata = 8'h34; tick();
      sl_hold_n = 1; sl_wr_n = 1; sr_wr_n = 1; tick();
      chk(sl_valid && sl_rdata == 8'h01, "R10 hold drops write", sl_rdata, 8'h01);
      chk(sr_valid && sr_rdata == 8'h34, "R10 slave write", sr_rdata, 8'h34);
      sl_addr = 10'd8; tick();
      chk(sl_cf_n && sr_cf_n, "R10 slave no conflict", {sl_cf_n, sr_cf_n}, 3);
      chk(sl_rdata == 8'h34 && sr_rdata == 8'h34, "R10 slave shared read", sl_rdata, 8'h34);
      sl_sel_n = 1; sr_sel_n = 1; tick();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule